// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory. It watches the access strobes of both ports and drives one active-low interrupt line to each port. The two highest addresses of the shared space are reserved as mailboxes, one per port.

Port A's mailbox is the second-highest address (0xFFE with the default 12-bit address). Port B's mailbox is the highest address (0xFFF). When one port writes into its partner's mailbox, the partner is interrupted. The partner acknowledges by reading its own mailbox, which releases its interrupt line. The message data itself lives in the memory array and is not handled here. Only the address decode and the two flags are in this block.

A feature enable input chooses between two behaviours. When it is high, the mailbox addresses raise and clear interrupts as described above. When it is low, they act as plain storage and have no side effects.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is active, and directly after it, both `a_irq_n` and `b_irq_n` are high (inactive).
- R2: A port B write (`b_en`=1, `b_we`=1) to address 2^ADDR_W-2 with `feat_en`=1 drives `a_irq_n` low after the next rising clock edge.
- R3: A port A read (`a_en`=1, `a_we`=0) of address 2^ADDR_W-2 with `feat_en`=1 returns `a_irq_n` high after the next edge, unless R9 applies.
- R4: A port A write to address 2^ADDR_W-1 with `feat_en`=1 drives `b_irq_n` low after the next edge.
- R5: A port B read of address 2^ADDR_W-1 with `feat_en`=1 returns `b_irq_n` high after the next edge, unless R9 applies.
- R6: With `feat_en`=0, no access on either port changes either interrupt line.
- R7: An access with its port enable low neither sets nor clears any interrupt.
- R8: A port writing to its own mailbox address leaves both interrupt lines unchanged.
- R9: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: Accesses to addresses other than the two mailboxes leave both interrupt lines unchanged.
- R11: A raised interrupt stays low until its clearing read, across any number of unrelated cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_en | input | 1 | 1 = mailbox addresses act as interrupt sources |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A address |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B address |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The access presented in a cycle takes effect at the following rising edge. Both interrupt lines are registered, so every result is due exactly one cycle after its stimulus. The driver applies each access on the falling edge and queues the line levels that a requirement-level model predicts. The monitor removes one entry per rising edge and compares it a quarter period after that edge, so it never samples on the edge itself. Simultaneous set and clear, disabled-feature accesses and gated port enables all pass through the same one-cycle scoreboard path.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned NUM_PORTS = 2;

    // Decoded mailbox events for one port in one cycle
    typedef struct packed {
        logic rd_own;   // read of this port's own mailbox
        logic wr_peer;  // write into the partner's mailbox
    } port_hits_t;

    // Registered state of the controller
    typedef struct packed {
        logic [NUM_PORTS-1:0] flag;  // 1 = interrupt pending for port index
    } mbox_state_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              feat_en,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output port_hits_t        hits
);
    logic active;

    always_comb begin
        active       = feat_en && en;
        hits.rd_own  = active && !we && (addr == OWN_BOX);
        hits.wr_peer = active &&  we && (addr == PEER_BOX);
    end
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_A    = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] BOX_B    = TOP_ADDR;

    logic [NUM_PORTS-1:0]             p_en;
    logic [NUM_PORTS-1:0]             p_we;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    port_hits_t [NUM_PORTS-1:0]       p_hits;

    assign p_en   = {b_en, a_en};
    assign p_we   = {b_we, a_we};
    assign p_addr = {b_addr, a_addr};

    // Index 0 is port A, index 1 is port B
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
        localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_B : BOX_A;
        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) dec_i (
            .feat_en (feat_en),
            .en      (p_en[p]),
            .we      (p_we[p]),
            .addr    (p_addr[p]),
            .hits    (p_hits[p])
        );
    end

    mbox_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            // partner's write to this port's box sets; set wins over clear
            if (p_hits[NUM_PORTS-1-p].wr_peer)
                state_d.flag[p] = 1'b1;
            else if (p_hits[p].rd_own)
                state_d.flag[p] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign a_irq_n = ~state_q.flag[0];
    assign b_irq_n = ~state_q.flag[1];
endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              feat_en,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_irq_n,
    input logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] HI_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_MAIL   = HI_ADDR - 1'b1;

    logic b_sets_a, a_sets_b, a_acks, b_acks;
    assign b_sets_a = feat_en && b_en && b_we && (b_addr == A_MAIL);
    assign a_sets_b = feat_en && a_en && a_we && (a_addr == HI_ADDR);
    assign a_acks   = feat_en && a_en && !a_we && (a_addr == A_MAIL);
    assign b_acks   = feat_en && b_en && !b_we && (b_addr == HI_ADDR);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) reset_idle_chk : assert (a_irq_n && b_irq_n);
    end

    // R2
    a_set_chk : assert property (@(posedge clk) disable iff (!rst_n)
        b_sets_a |=> !a_irq_n);

    // R4
    b_set_chk : assert property (@(posedge clk) disable iff (!rst_n)
        a_sets_b |=> !b_irq_n);

    // R3
    a_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (a_acks && !b_sets_a) |=> a_irq_n);

    // R5
    b_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (b_acks && !a_sets_b) |=> b_irq_n);

    // R6
    feat_off_chk : assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |=> ($stable(a_irq_n) && $stable(b_irq_n)));

    // R7
    ports_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en && !b_en) |=> ($stable(a_irq_n) && $stable(b_irq_n)));
endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .feat_en (feat_en),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .a_irq_n (a_irq_n),
    .b_irq_n (b_irq_n)
);

// File: tb/mbox_irq_ctrl_tb_top.sv
module mbox_irq_ctrl_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 12;
    localparam logic [AW-1:0] MB_A = 12'hFFE;
    localparam logic [AW-1:0] MB_B = 12'hFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic feat_en = 1'b0;
    logic a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;
    logic ref_a = 1'b0, ref_b = 1'b0;
    logic [1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    task automatic compare(input logic [1:0] exp, input string tag);
        checks++;
        if ({a_irq_n, b_irq_n} !== exp) begin
            errors++;
            $display("FAIL %s: got a_irq_n/b_irq_n=%b%b expected %b%b",
                     tag, a_irq_n, b_irq_n, exp[1], exp[0]);
        end
    endtask

    // Driver: apply one access cycle and queue the predicted outcome
    task automatic step(input logic fe,
                        input logic ae, input logic aw, input logic [AW-1:0] aa,
                        input logic be, input logic bw, input logic [AW-1:0] ba,
                        input string tag);
        logic sa, ca, sb, cb;
        @(negedge clk);
        feat_en = fe;
        a_en = ae; a_we = aw; a_addr = aa;
        b_en = be; b_we = bw; b_addr = ba;
        sa = fe && be && bw  && (ba == MB_A);
        ca = fe && ae && !aw && (aa == MB_A);
        sb = fe && ae && aw  && (aa == MB_B);
        cb = fe && be && !bw && (ba == MB_B);
        ref_a = sa | (ref_a & ~ca);
        ref_b = sb | (ref_b & ~cb);
        exp_q.push_back({~ref_a, ~ref_b});
        tag_q.push_back(tag);
    endtask

    // Monitor: one result per rising edge, sampled a quarter period later
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(2'b11, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare(2'b11, "R1 after reset");

        step(1, 1,0,12'h000, 1,0,12'h010, "R10 plain reads");
        step(1, 0,0,12'h000, 1,1,MB_A,    "R2 B writes A box");
        step(1, 1,0,12'h123, 1,1,12'hFFD, "R11 unrelated access keeps A low");
        step(1, 0,0,12'h000, 0,0,12'h000, "R11 idle keeps A low");
        step(1, 1,0,MB_A,    0,0,12'h000, "R3 A reads own box");
        step(1, 1,1,MB_B,    0,0,12'h000, "R4 A writes B box");
        step(1, 0,0,12'h000, 1,1,MB_B,    "R8 B writes own box");
        step(1, 0,0,12'h000, 1,0,MB_B,    "R5 B reads own box");
        step(1, 1,1,MB_A,    0,0,12'h000, "R8 A writes own box");
        step(0, 0,0,12'h000, 1,1,MB_A,    "R6 feature off, B writes A box");
        step(0, 1,1,MB_B,    0,0,12'h000, "R6 feature off, A writes B box");
        step(1, 0,0,12'h000, 0,1,MB_A,    "R7 B enable low");
        step(1, 0,0,12'h000, 1,1,MB_A,    "R2 set A again");
        step(0, 1,0,MB_A,    0,0,12'h000, "R6 feature off, A reads own box");
        step(1, 0,0,MB_A,    0,0,12'h000, "R7 A enable low on own box read");
        step(1, 1,0,MB_A,    1,1,MB_A,    "R9 set and clear A together");
        step(1, 1,0,MB_A,    0,0,12'h000, "R3 clear A");
        step(1, 1,1,MB_B,    1,0,MB_B,    "R9 set and clear B together");
        step(1, 1,1,12'hFFD, 1,1,12'h000, "R10 writes elsewhere");
        step(1, 0,0,12'h000, 1,0,MB_B,    "R5 clear B");

        @(negedge clk);
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule